// File: doc/BRIEF.md
# Edge-Triggered Interrupt Request Capture

This block turns edges on four port pins and single-cycle strobes from internal peripherals into a six-bit register of pending interrupt requests. Each of the four external request lines has an edge catcher. The catcher is a flip-flop that is set directly by the selected edge of its pin, with no clock involved. Behind it sits a two-stage resynchronizer running on the system clock. Because of this, pulses far shorter than a clock period are still seen. Internal event strobes are synchronous and are ORed into the same request lines. Line 3 can take its external input from either of two pins.

A pending bit stays set until the processor writes a one-cycle clear strobe for that bit. A request that arrives in the same cycle as its clear is kept. A small lookup also turns a request-line index into the address of its two-byte entry in the vector table. Priority, masking and the vector fetch itself belong to other blocks.

Top module: `irq_edge_capture`

## Requirements
- R1: While `rst` is high, every pending bit reads 0 from the next clock edge on, and edges seen during reset are discarded.
- R2: Pin 2 feeds line 0, pin 3 feeds line 1 and pin 1 feeds line 2.
- R3: Line 3 follows pin 0 when `irq3_alt_sel` is 0 and pin 2 when it is 1. The pin that is not selected has no effect on line 3.
- R4: `fall_edge[p]` = 0 makes pin p sensitive to rising edges only, and 1 makes it sensitive to falling edges only. The opposite edge sets nothing.
- R5: A pin edge placed between clock edges shows in `pending` after the third rising clock edge that follows it, and not after the second.
- R6: A pin pulse much shorter than a clock period, lying wholly between two clock edges, is still captured.
- R7: `ser_rx_evt` sets bit 3, `tmr0_evt` and `ser_tx_evt` set bit 4, and `tmr1_evt` sets bit 5, in each case at the next clock edge.
- R8: A pending bit holds its value until `pend_clr` for that bit is high at a clock edge, which clears it.
- R9: When a set and a clear reach the same bit at the same edge, the bit ends up set.
- R10: Once a captured edge has moved into the resynchronizer, the catcher is free again, and a later edge on the same pin is captured once more.
- R11: `vec_addr` equals 2 × `vec_index` for indices 0 to 5, giving the first of that line's two bytes. Indices 6 and 7 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset; also clears the edge catchers asynchronously |
| port_pin | input | 4 | External request pins 0..3 |
| fall_edge | input | 4 | Per-pin edge choice: 0 rising, 1 falling |
| irq3_alt_sel | input | 1 | Source of line 3: 0 pin 0, 1 pin 2 |
| ser_rx_evt | input | 1 | Serial-receive event strobe (line 3) |
| tmr0_evt | input | 1 | Timer 0 event strobe (line 4) |
| ser_tx_evt | input | 1 | Serial-transmit event strobe (line 4) |
| tmr1_evt | input | 1 | Timer 1 event strobe (line 5) |
| pend_clr | input | 6 | Per-bit clear strobes from the processor |
| vec_index | input | 3 | Request line whose vector address is wanted |
| pending | output | 6 | Pending request register |
| vec_addr | output | 8 | Vector table address of the selected line |

## Verification
The assertions assume that `fall_edge` and `irq3_alt_sel` change only while reset is held. Changing either one flips the catcher's trigger input, which looks like an edge. The bench therefore sets both only inside its reset sequence. The assertions also assume that pin edges never coincide with a rising clock edge. The stimulus moves pins only a fraction of a period after a falling clock edge, so the order in which the catcher and the resynchronizer update is always the same.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
   localparam int unsigned LINE_CNT = 6;   // request lines in the pending register
   localparam int unsigned EXT_CNT  = 4;   // lines that own an edge catcher

   // default pin feeding each externally driven line
   function automatic int unsigned ext_pin_main(input int unsigned line);
      case (line)
         0:       return 2;
         1:       return 3;
         2:       return 1;
         default: return 0;
      endcase
   endfunction

   localparam int unsigned IRQ3_ALT_PIN = 2;  // alternative pin for line 3
endpackage

// File: rtl/irq_edge_catcher.sv
module irq_edge_catcher #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_in,
   input  logic fall_sel,
   output logic req_pulse
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("irq_edge_catcher: SYNC_STAGES must be at least 2");
   end

   logic                   trig;
   logic                   caught;
   logic                   catch_clr;
   logic [SYNC_STAGES-1:0] sync_q;

   assign trig      = pin_in ^ fall_sel;
   // release the catcher once its content sits in the first stage
   assign catch_clr = rst | sync_q[0];

   always_ff @(posedge trig or posedge catch_clr) begin
      if (catch_clr) caught <= 1'b0;
      else           caught <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], caught};
   end

   assign req_pulse = sync_q[SYNC_STAGES-1];

   // R10: first stage holds a capture for exactly one cycle, then frees the catcher
   a_r10_release: assert property (@(posedge clk) disable iff (rst)
      sync_q[0] |=> !sync_q[0]);
   // R5: a capture advances one stage per clock
   a_r5_advance: assert property (@(posedge clk) disable iff (rst)
      sync_q[0] |=> sync_q[1]);
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
   parameter int unsigned LINES = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LINES-1:0] set_vec,
   input  logic [LINES-1:0] clr_vec,
   output logic [LINES-1:0] pending
);
   always_ff @(posedge clk) begin
      if (rst) pending <= '0;
      else     pending <= (pending & ~clr_vec) | set_vec;
   end

   for (genvar i = 0; i < LINES; i++) begin : g_chk
      a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
         set_vec[i] |=> pending[i]);
      a_r8_clear: assert property (@(posedge clk) disable iff (rst)
         (clr_vec[i] && !set_vec[i]) |=> !pending[i]);
      a_r8_hold: assert property (@(posedge clk) disable iff (rst)
         (pending[i] && !clr_vec[i]) |=> pending[i]);
      a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
         (!pending[i] && !set_vec[i]) |=> !pending[i]);
   end
endmodule

// File: rtl/irq_vector_lut.sv
module irq_vector_lut #(
   parameter int unsigned LINES = 6,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned VEC_W = 8
) (
   input  logic [IDX_W-1:0] vec_index,
   output logic [VEC_W-1:0] vec_addr
);
   localparam int unsigned TOP_ADDR = 2 * LINES - 1;

   if ((1 << IDX_W) < LINES) begin : g_bad_idx
      $error("irq_vector_lut: IDX_W too small for LINES");
   end
   if ((1 << VEC_W) <= TOP_ADDR) begin : g_bad_vec
      $error("irq_vector_lut: VEC_W too small for the vector table");
   end

   logic [VEC_W-1:0] idx_ext;
   assign idx_ext = VEC_W'(vec_index);

   always_comb begin
      if (int'(vec_index) < int'(LINES)) vec_addr = idx_ext << 1;
      else                               vec_addr = '0;
   end
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
   parameter int unsigned PIN_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IDX_W       = 3,
   parameter int unsigned VEC_W       = 8
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic [PIN_W-1:0]                     port_pin,
   input  logic [PIN_W-1:0]                     fall_edge,
   input  logic                                 irq3_alt_sel,
   input  logic                                 ser_rx_evt,
   input  logic                                 tmr0_evt,
   input  logic                                 ser_tx_evt,
   input  logic                                 tmr1_evt,
   input  logic [irq_cap_pkg::LINE_CNT-1:0]     pend_clr,
   input  logic [IDX_W-1:0]                     vec_index,
   output logic [irq_cap_pkg::LINE_CNT-1:0]     pending,
   output logic [VEC_W-1:0]                     vec_addr
);
   import irq_cap_pkg::*;

   if (PIN_W < 4) begin : g_bad_pins
      $error("irq_edge_capture: PIN_W must cover pins 0..3");
   end

   logic [EXT_CNT-1:0]  ext_req;
   logic [LINE_CNT-1:0] set_vec;

   for (genvar l = 0; l < EXT_CNT; l++) begin : g_ext
      localparam int unsigned MAIN_PIN = ext_pin_main(l);
      logic src_pin;
      logic src_fall;
      if (l == 3) begin : g_muxed
         assign src_pin  = irq3_alt_sel ? port_pin[IRQ3_ALT_PIN]  : port_pin[MAIN_PIN];
         assign src_fall = irq3_alt_sel ? fall_edge[IRQ3_ALT_PIN] : fall_edge[MAIN_PIN];
      end else begin : g_fixed
         assign src_pin  = port_pin[MAIN_PIN];
         assign src_fall = fall_edge[MAIN_PIN];
      end
      irq_edge_catcher #(.SYNC_STAGES(SYNC_STAGES)) u_catch (
         .clk       (clk),
         .rst       (rst),
         .pin_in    (src_pin),
         .fall_sel  (src_fall),
         .req_pulse (ext_req[l])
      );
   end

   assign set_vec = {tmr1_evt,
                     tmr0_evt | ser_tx_evt,
                     ext_req[3] | ser_rx_evt,
                     ext_req[2:0]};

   irq_pending_reg #(.LINES(LINE_CNT)) u_pend (
      .clk     (clk),
      .rst     (rst),
      .set_vec (set_vec),
      .clr_vec (pend_clr),
      .pending (pending)
   );

   irq_vector_lut #(.LINES(LINE_CNT), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_vec (
      .vec_index (vec_index),
      .vec_addr  (vec_addr)
   );

   // R1: reset empties the pending register
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (pending == '0));
   // R7: timer 1 strobe lands in line 5 at the next edge
   a_r7_tmr1: assert property (@(posedge clk) disable iff (rst)
      tmr1_evt |=> pending[5]);
   // R7: receive strobe lands in line 3 at the next edge
   a_r7_srx: assert property (@(posedge clk) disable iff (rst)
      ser_rx_evt |=> pending[3]);
   // R11: address always points inside the table
   a_r11_in_table: assert property (@(posedge clk) disable iff (rst)
      int'(vec_addr) < int'(2 * LINE_CNT));
endmodule

// File: tb/irq_edge_capture_tb.sv
`timescale 1ns/100ps
module irq_edge_capture_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] pins = 4'b0;
   logic [3:0] pol  = 4'b0;
   logic       alt  = 1'b0;
   logic       srx = 0, t0 = 0, stx = 0, t1 = 0;
   logic [5:0] clr = '0;
   logic [2:0] vsel = '0;
   wire  [5:0] pend;
   wire  [7:0] vaddr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference
   bit         m_catch [4];
   bit         m_s1 [4];
   bit         m_s2 [4];
   logic [5:0] m_pend = '0;

   always #2 clk = ~clk;

   irq_edge_capture u_dut (
      .clk(clk), .rst(rst), .port_pin(pins), .fall_edge(pol),
      .irq3_alt_sel(alt), .ser_rx_evt(srx), .tmr0_evt(t0),
      .ser_tx_evt(stx), .tmr1_evt(t1), .pend_clr(clr),
      .vec_index(vsel), .pending(pend), .vec_addr(vaddr)
   );

   function automatic int src_of(input int line);
      case (line)
         0: return 2;
         1: return 3;
         2: return 1;
         default: return alt ? 2 : 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int l = 0; l < 4; l++) begin
            m_catch[l] = 0; m_s1[l] = 0; m_s2[l] = 0;
         end
         m_pend = '0;
      end else begin
         logic [5:0] setv;
         setv = {t1, t0 | stx, m_s2[3] | srx, m_s2[2], m_s2[1], m_s2[0]};
         m_pend = (m_pend & ~clr) | setv;
         for (int l = 0; l < 4; l++) begin
            m_s2[l] = m_s1[l];
            m_s1[l] = m_catch[l];
            if (m_s1[l]) m_catch[l] = 0;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // every cycle: pending against the model (R5/R8)
   always @(negedge clk) begin
      if (!rst && !done) chk("R5/R8", "cycle model", 32'(pend), 32'(m_pend));
   end

   task automatic cycle(input int n = 1);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic set_pin(input int p, input bit v);
      bit old;
      old = pins[p];
      pins[p] = v;
      for (int l = 0; l < 4; l++) begin
         if (src_of(l) == p) begin
            bit act;
            act = pol[p] ? (old && !v) : (!old && v);
            if (act && !m_s1[l] && !rst) m_catch[l] = 1;
         end
      end
   endtask

   task automatic do_reset(input logic [3:0] p_pol, input bit p_alt, input logic [3:0] p_pins);
      rst = 1'b1;
      pins = p_pins;
      pol = p_pol;
      alt = p_alt;
      cycle(3);
      chk("R1", "pending in reset", 32'(pend), 0);
      rst = 1'b0;
   endtask

   task automatic clear_bits(input logic [5:0] m);
      clr = m;
      cycle();
      clr = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // phase A: rising edges, line 3 on pin 0
      do_reset(4'b0000, 1'b0, 4'b0000);
      cycle();
      chk("R1", "pending after reset", 32'(pend), 0);

      set_pin(2, 1);
      cycle(2);
      chk("R5", "not yet after two edges", 32'(pend[0]), 0);
      cycle();
      chk("R5", "set after third edge", 32'(pend[0]), 1);
      chk("R2", "pin2 only drives line0", 32'(pend), 32'(6'b000001));
      set_pin(3, 1); cycle(3);
      chk("R2", "pin3 drives line1", 32'(pend[1]), 1);
      set_pin(1, 1); cycle(3);
      chk("R2", "pin1 drives line2", 32'(pend[2]), 1);
      set_pin(0, 1); cycle(3);
      chk("R3", "pin0 drives line3 when alt=0", 32'(pend), 32'(6'b001111));
      cycle(8);
      chk("R8", "bits hold without clear", 32'(pend), 32'(6'b001111));
      clear_bits(6'b001111);
      chk("R8", "clear strobe empties bits", 32'(pend), 0);

      for (int p = 0; p < 4; p++) set_pin(p, 0);
      cycle(5);
      chk("R4", "falling edges ignored when rising selected", 32'(pend), 0);

      // R6: sub-period pulse on pin 3
      set_pin(3, 1);
      #0.4;
      set_pin(3, 0);
      cycle(3);
      chk("R6", "narrow pulse captured", 32'(pend[1]), 1);
      clear_bits(6'b000010);

      // R10: second edge after the catcher is released
      set_pin(3, 1); cycle(2);
      set_pin(3, 0); cycle();
      chk("R10", "first capture", 32'(pend[1]), 1);
      set_pin(3, 1);
      clr = 6'b000010;
      cycle();
      clr = '0;
      chk("R8", "cleared before second capture lands", 32'(pend[1]), 0);
      cycle(2);
      chk("R10", "second edge captured again", 32'(pend[1]), 1);
      clear_bits(6'b111111);

      // R7: internal strobes
      srx = 1; cycle(); srx = 0;
      chk("R7", "serial receive to line3", 32'(pend), 32'(6'b001000));
      t0 = 1; cycle(); t0 = 0;
      chk("R7", "timer0 to line4", 32'(pend), 32'(6'b011000));
      clear_bits(6'b111111);
      stx = 1; cycle(); stx = 0;
      chk("R7", "serial transmit to line4", 32'(pend), 32'(6'b010000));
      t1 = 1; cycle(); t1 = 0;
      chk("R7", "timer1 to line5", 32'(pend), 32'(6'b110000));

      // R9: set and clear together
      t1 = 1; clr = 6'b100000; cycle(); t1 = 0; clr = '0;
      chk("R9", "set beats clear", 32'(pend[5]), 1);
      clr = 6'b100000; cycle(); clr = '0;
      chk("R8", "clear alone", 32'(pend[5]), 0);

      // phase B: falling edges, line 3 on pin 2
      do_reset(4'b1111, 1'b1, 4'b1111);
      cycle();
      chk("R1", "reset cleared earlier bits", 32'(pend), 0);
      set_pin(2, 0); cycle(3);
      chk("R3", "pin2 falling drives lines 0 and 3", 32'(pend), 32'(6'b001001));
      chk("R4", "falling edge accepted", 32'(pend[0]), 1);
      clear_bits(6'b111111);
      set_pin(0, 0); cycle(3);
      chk("R3", "pin0 ignored when alt=1", 32'(pend), 0);
      set_pin(2, 1); set_pin(3, 0); cycle(4);
      chk("R4", "rising ignored, falling pin3 taken", 32'(pend), 32'(6'b000010));

      // R11: vector addresses
      for (int i = 0; i < 8; i++) begin
         vsel = 3'(i);
         #0.2;
         chk("R11", "vector address", 32'(vaddr), (i < 6) ? 32'(2 * i) : 0);
      end

      cycle();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule